// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand addressing request into a memory location for a 16-bit processor that uses segmented memory. A request names up to one base pointer (BX or BP), up to one index pointer (SI or DI) and a displacement of zero, eight or sixteen bits. The block adds them to form a 16-bit effective offset, picks the segment register that applies, and forms a 20-bit physical address from the two.

The segment is the stack segment when BP takes part and the data segment otherwise, unless a segment override names one of the four segment registers directly. Requests that pair both base pointers or both index pointers, or that use the reserved displacement code, are rejected. A rejected request raises a flag and leaves the address outputs at their earlier values. All results leave through one register stage, so each request is answered one clock after it is sampled.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address is the selected segment value times 16 plus the effective offset, truncated to 20 bits (segment FFFFh with offset 0020h gives 00010h).
- R2: The effective offset is the sum of the selected pointer registers and the displacement, truncated to 16 bits.
- R3: disp_size selects the displacement: 0 adds nothing, 1 adds disp[7:0] sign-extended to 16 bits, 2 adds disp[15:0].
- R4: With no override, a request whose mask includes BP uses the stack segment; every other request uses the data segment.
- R5: When ovr_en is 1, ovr_sel picks the segment in place of the default, with codes 0 = ES, 1 = CS, 2 = SS, 3 = DS; seg_used reports the segment with the same codes.
- R6: reg_mask bits are [3] BX, [2] BP, [1] SI, [0] DI. A request with both BX and BP, or both SI and DI, sets illegal for one cycle, keeps out_valid low and leaves eff_off, seg_used and phys_addr unchanged.
- R7: disp_size 3 is reserved; a request using it is rejected as in R6.
- R8: A request with an empty mask and disp_size 2 is legal and gives an effective offset equal to disp.
- R9: A legal request sampled at a clock edge sets out_valid and updates the outputs at that edge; when req_valid is 0, out_valid and illegal are 0 after the edge and the address outputs hold.
- R10: Reset (rst_n low) clears out_valid, illegal, eff_off, seg_used and phys_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| reg_mask | input | 4 | Pointer select: [3] BX, [2] BP, [1] SI, [0] DI |
| disp_size | input | 2 | Displacement kind: 0 none, 1 byte, 2 word, 3 reserved |
| disp | input | 16 | Displacement value |
| ptr_bx | input | 16 | BX pointer value |
| ptr_bp | input | 16 | BP pointer value |
| ptr_si | input | 16 | SI pointer value |
| ptr_di | input | 16 | DI pointer value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Registered result is from a legal request |
| illegal | output | 1 | Previous request was rejected |
| eff_off | output | 16 | Effective offset |
| seg_used | output | 2 | Segment code used |
| phys_addr | output | 20 | Physical address |

## Verification
Every result of this block is due exactly one clock after the request is sampled: offset, segment code, physical address, out_valid and the illegal flag all come from the single output register. The bench therefore drives each request just after a rising edge and compares all outputs one nanosecond after the following rising edge, against a model that keeps the last accepted values so that holds on rejected or idle cycles are checked against the right numbers.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int OFF_W   = 16;
  localparam int SEG_SH  = 4;
  localparam int PA_W    = OFF_W + SEG_SH;
  localparam int NPTR    = 4;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_code_t;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_BYTE = 2'd1,
    DSZ_WORD = 2'd2,
    DSZ_RSVD = 2'd3
  } dsz_t;

  // displacement widened to offset width
  function automatic logic [OFF_W-1:0] widen_disp(input logic [1:0] dsz,
                                                  input logic [OFF_W-1:0] d);
    case (dsz)
      DSZ_BYTE: widen_disp = {{(OFF_W-8){d[7]}}, d[7:0]};
      DSZ_WORD: widen_disp = d;
      default:  widen_disp = '0;
    endcase
  endfunction

  // segment scaled and added to offset, wrapping at PA_W bits
  function automatic logic [PA_W-1:0] seg_plus_off(input logic [OFF_W-1:0] seg,
                                                   input logic [OFF_W-1:0] off);
    seg_plus_off = {seg, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, off};
  endfunction
endpackage

// File: rtl/ea_offset.sv
module ea_offset
  import ea_pkg::*;
(
  input  logic [NPTR-1:0]             mask,
  input  logic [1:0]                  dsz,
  input  logic [OFF_W-1:0]            disp,
  input  logic [NPTR-1:0][OFF_W-1:0]  ptrs,
  output logic [OFF_W-1:0]            off,
  output logic                        combo_bad
);
  logic [NPTR-1:0][OFF_W-1:0] term;

  genvar g;
  generate
    for (g = 0; g < NPTR; g++) begin : g_term
      assign term[g] = mask[g] ? ptrs[g] : '0;
    end
  endgenerate

  // mask layout: [3] BX, [2] BP, [1] SI, [0] DI
  assign combo_bad = (mask[3] & mask[2]) | (mask[1] & mask[0]) | (dsz == DSZ_RSVD);

  always_comb begin
    off = widen_disp(dsz, disp);
    for (int i = 0; i < NPTR; i++) off = off + term[i];
  end
endmodule

// File: rtl/ea_segsel.sv
module ea_segsel
  import ea_pkg::*;
(
  input  logic             uses_bp,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [OFF_W-1:0] s_es,
  input  logic [OFF_W-1:0] s_cs,
  input  logic [OFF_W-1:0] s_ss,
  input  logic [OFF_W-1:0] s_ds,
  output logic [1:0]       code,
  output logic [OFF_W-1:0] value
);
  logic [1:0] dflt;
  assign dflt = uses_bp ? SEG_SS : SEG_DS;
  assign code = ovr_en ? ovr_sel : dflt;

  always_comb begin
    case (code)
      SEG_ES:  value = s_es;
      SEG_CS:  value = s_cs;
      SEG_SS:  value = s_ss;
      default: value = s_ds;
    endcase
  end
endmodule

// File: rtl/ea_phys.sv
module ea_phys
  import ea_pkg::*;
(
  input  logic [OFF_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  assign pa = seg_plus_off(seg, off);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        reg_mask,
  input  logic [1:0]        disp_size,
  input  logic [15:0]       disp,
  input  logic [15:0]       ptr_bx,
  input  logic [15:0]       ptr_bp,
  input  logic [15:0]       ptr_si,
  input  logic [15:0]       ptr_di,
  input  logic [15:0]       seg_es,
  input  logic [15:0]       seg_cs,
  input  logic [15:0]       seg_ss,
  input  logic [15:0]       seg_ds,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  output logic              out_valid,
  output logic              illegal,
  output logic [15:0]       eff_off,
  output logic [1:0]        seg_used,
  output logic [19:0]       phys_addr
);
  logic [NPTR-1:0][OFF_W-1:0] ptr_vec;
  logic [OFF_W-1:0] off_w;
  logic             combo_bad_w;
  logic [1:0]       seg_code_w;
  logic [OFF_W-1:0] seg_val_w;
  logic [PA_W-1:0]  pa_w;
  logic             accept_w;
  logic             reject_w;

  assign ptr_vec = {ptr_bx, ptr_bp, ptr_si, ptr_di};

  ea_offset u_off (
    .mask(reg_mask), .dsz(disp_size), .disp(disp), .ptrs(ptr_vec),
    .off(off_w), .combo_bad(combo_bad_w)
  );

  ea_segsel u_seg (
    .uses_bp(reg_mask[2]), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .s_es(seg_es), .s_cs(seg_cs), .s_ss(seg_ss), .s_ds(seg_ds),
    .code(seg_code_w), .value(seg_val_w)
  );

  ea_phys u_pa (.seg(seg_val_w), .off(off_w), .pa(pa_w));

  assign accept_w = req_valid & ~combo_bad_w;
  assign reject_w = req_valid &  combo_bad_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      eff_off   <= '0;
      seg_used  <= '0;
      phys_addr <= '0;
    end else begin
      out_valid <= accept_w;
      illegal   <= reject_w;
      if (accept_w) begin
        eff_off   <= off_w;
        seg_used  <= seg_code_w;
        phys_addr <= pa_w;
      end
    end
  end

  // port-level legality, stated independently of the offset unit
  logic legal_req;
  assign legal_req = req_valid && !(reg_mask[3] && reg_mask[2]) &&
                     !(reg_mask[1] && reg_mask[0]) && (disp_size != 2'd3);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, illegal}));

  p_hold_on_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_mask[3] && reg_mask[2]) |=> (illegal && $stable(phys_addr) && $stable(eff_off)));

  p_rsvd_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && disp_size == 2'd3) |=> (illegal && !out_valid));

  p_bp_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && !ovr_en && reg_mask[2]) |=> (seg_used == 2'd2));

  p_data_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && !ovr_en && !reg_mask[2]) |=> (seg_used == 2'd3));

  p_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && ovr_en) |=> (seg_used == $past(ovr_sel)));

  p_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req && reg_mask == 4'd0 && disp_size == 2'd2) |=> (eff_off == $past(disp)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !illegal && $stable(phys_addr) && $stable(seg_used)));
endmodule

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] reg_mask = '0;
  logic [1:0] disp_size = '0;
  logic [15:0] disp = '0, ptr_bx = '0, ptr_bp = '0, ptr_si = '0, ptr_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic ovr_en = 1'b0;
  logic [1:0] ovr_sel = '0;
  logic out_valid, illegal;
  logic [15:0] eff_off;
  logic [1:0] seg_used;
  logic [19:0] phys_addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_off = '0;
  logic [1:0]  m_seg = '0;
  logic [19:0] m_pa = '0;
  logic        m_val = 1'b0, m_ill = 1'b0;

  always #2 clk = ~clk;

  seg_addr_gen dut (.*);

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [15:0] x_off();
    int s = 0;
    if (reg_mask[3]) s += ptr_bx;
    if (reg_mask[2]) s += ptr_bp;
    if (reg_mask[1]) s += ptr_si;
    if (reg_mask[0]) s += ptr_di;
    if (disp_size == 2'd1) s += (disp[7] ? int'(disp[7:0]) - 256 : int'(disp[7:0]));
    if (disp_size == 2'd2) s += disp;
    return s[15:0];
  endfunction

  function automatic logic [1:0] x_seg();
    if (ovr_en) return ovr_sel;
    return reg_mask[2] ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [19:0] x_pa(input logic [1:0] c, input logic [15:0] o);
    int base;
    base = (c == 0) ? seg_es : (c == 1) ? seg_cs : (c == 2) ? seg_ss : seg_ds;
    return 20'((base * 16 + o) % 1048576);
  endfunction

  function automatic bit x_bad();
    return (reg_mask[3] && reg_mask[2]) || (reg_mask[1] && reg_mask[0]) || disp_size == 2'd3;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are set just after a rising edge; outputs compared 1 ns after the next
  task automatic step(input string tag);
    if (req_valid) begin
      if (x_bad()) begin m_val = 0; m_ill = 1; end
      else begin
        m_val = 1; m_ill = 0;
        m_off = x_off(); m_seg = x_seg(); m_pa = x_pa(m_seg, m_off);
      end
    end else begin m_val = 0; m_ill = 0; end
    @(posedge clk); #1;
    check({tag, " status"}, {62'd0, out_valid, illegal}, {62'd0, m_val, m_ill});
    check({tag, " data"}, {26'd0, eff_off, seg_used, phys_addr}, {26'd0, m_off, m_seg, m_pa});
  endtask

  task automatic req(input logic [3:0] m, input logic [1:0] ds, input logic [15:0] d,
                     input logic oe, input logic [1:0] os);
    req_valid = 1; reg_mask = m; disp_size = ds; disp = d; ovr_en = oe; ovr_sel = os;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {45'd0, out_valid, illegal, eff_off, seg_used, phys_addr}, 64'd0);
    rst_n = 1;
    seg_es = 16'h2000; seg_cs = 16'h3000; seg_ss = 16'h4000; seg_ds = 16'h1230;
    ptr_bx = 16'hFFFF; ptr_bp = 16'h0100; ptr_si = 16'h0002; ptr_di = 16'h0010;

    req(4'b0000, 2'd2, 16'h0045, 0, 0); step("R8 R1 direct");
    check("R1 example", {44'd0, phys_addr}, 64'h12345);
    req(4'b1010, 2'd0, 16'h0, 0, 0);    step("R2 offset wrap");
    check("R2 wrap value", {48'd0, eff_off}, 64'h0001);
    req(4'b0110, 2'd1, 16'h1280, 0, 0); step("R3 R4 neg byte with BP");
    check("R3 sign extend", {48'd0, eff_off}, 64'h0082);
    check("R4 stack seg", {62'd0, seg_used}, 64'd2);
    req(4'b0001, 2'd1, 16'h007F, 0, 0); step("R3 R4 pos byte DI");
    check("R4 data seg", {62'd0, seg_used}, 64'd3);
    req(4'b0100, 2'd2, 16'h0, 1, 2'd1); step("R5 override CS");
    check("R5 code", {62'd0, seg_used}, 64'd1);
    seg_ds = 16'hFFFF;
    req(4'b0000, 2'd2, 16'h0020, 0, 0); step("R1 phys wrap");
    check("R1 wrap value", {44'd0, phys_addr}, 64'h00010);
    req(4'b1100, 2'd2, 16'h5555, 0, 0); step("R6 BX+BP");
    req(4'b0011, 2'd0, 16'h0, 1, 0);    step("R6 SI+DI");
    req(4'b1000, 2'd3, 16'h0, 0, 0);    step("R7 reserved size");
    req_valid = 0; reg_mask = 4'b0001;  step("R9 idle hold");
    step("R9 idle hold 2");

    for (int i = 0; i < 400; i++) begin
      req_valid = ($urandom % 5) != 0;
      reg_mask = 4'($urandom); disp_size = 2'($urandom); disp = 16'($urandom);
      ptr_bx = 16'($urandom); ptr_bp = 16'($urandom);
      ptr_si = 16'($urandom); ptr_di = 16'($urandom);
      seg_es = 16'($urandom); seg_cs = 16'($urandom);
      seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      ovr_en = ($urandom % 3) == 0; ovr_sel = 2'($urandom);
      step("R2 R1 R4 R5 R6 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule